// File: doc/BRIEF.md
# Dual-Rate Sample-Sleep Sequencer

This block sets the duty cycle of a low-power sensor front end. It drives an `awake` enable that powers the sensing path for a short window of `AWAKE_CYC` clock cycles and then lets it sleep. On the last cycle of each awake window it samples a signed digital field value. It then updates a latched binary output with hysteresis, and that output holds its value through sleep.

The operating mode is chosen on `mode_sel`. In the fixed-rate mode the windows repeat every `NORM_PERIOD` cycles. In the clock-gated mode a delayed copy of `ext_clk` sets awake and sleep directly. In the activity mode the block starts with slow windows every `SLOW_PERIOD` cycles. It moves to fast windows every `8*AWAKE_CYC` cycles once a sample flips the output. It drops back to the slow rate after `TIMEOUT_PERIODS*SLOW_PERIOD` cycles without a flip. All durations are parameters counted in clock cycles. `ext_clk` is expected to be synchronous to `clk`.

Top module: `sample_sleep_seq`

## Requirements
- R1: After reset is released, `sensor_out` is 0. If `mode_sel` is not 01, `awake` is 1 in the first cycle, so the first window starts at once.
- R2: With `mode_sel`=00, each period lasts `NORM_PERIOD` cycles, and `awake` is 1 for exactly the first `AWAKE_CYC` cycles of it.
- R3: The code `mode_sel`=11 behaves exactly like 00.
- R4: `mode_sel` takes effect only in the first cycle of a period, or in any cycle while the clock-gated mode is asleep. A change at any other time waits for the next period.
- R5: With `mode_sel`=10, the block starts at the slow rate, with periods of `SLOW_PERIOD` cycles and an `AWAKE_CYC`-cycle window at the start of each.
- R6: With `mode_sel`=10, a sample that changes `sensor_out` selects the fast rate at once. The period holding that sample, and every later one, lasts `8*AWAKE_CYC` cycles.
- R7: At the fast rate, once `TIMEOUT_PERIODS*SLOW_PERIOD` cycles pass after the last output-changing sample with no new change, the block returns to the slow rate. The running period then ends `SLOW_PERIOD` cycles after its start.
- R8: With `mode_sel`=01, `awake` follows `ext_clk`. A new level takes effect at the `AWAKE_CYC`-th rising clock edge that samples it, counting the first. A level that reverts sooner is ignored.
- R9: `field` is a two's complement value `FIELD_W` bits wide. A sample at or above `OP_THR` sets `sensor_out` to 1. A sample at or below `RP_THR` clears it to 0. Any value in between leaves it unchanged.
- R10: `field` is sampled only in the last awake cycle of a window, and `sensor_out` can change only at the clock edge that ends that cycle.
- R11: With `mode_sel`=01, the sample is taken in the last cycle that `awake` is 1, just before the delayed low level takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 fixed rate, 01 clock-gated, 10 activity, 11 same as 00 |
| ext_clk | input | 1 | Awake command for the clock-gated mode |
| field | input | FIELD_W | Signed field sample |
| awake | output | 1 | Power enable for the sensing path |
| sensor_out | output | 1 | Hysteretic latched output |

## Verification
The assertions check on every cycle that the output moves only at the edge after a sample. They also check that samples above the upper threshold or below the lower one force the output, that a flip in activity mode selects the fast rate, that the timeout counter stays in range, and that the gated level only moves toward the external input. Only the bench scenarios show the exact window and period lengths, the mode boundary rules, and the timeout fall-back timing. They also show that short external pulses are ignored and that the hysteresis holds across a full sweep of field values. The bench checks these cycle by cycle against a model written from the requirements.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED = 2'b00,
    MODE_GATED = 2'b01,
    MODE_ACT   = 2'b10,
    MODE_RSVD  = 2'b11
  } ssq_mode_e;
endpackage

// File: rtl/ssq_ext_gate.sv
module ssq_ext_gate #(
  parameter int AWAKE_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  output logic level_o,
  output logic fall_due_o
);
  localparam int EW = $clog2(AWAKE_CYC + 1);
  localparam logic [EW-1:0] LAST = EW'(AWAKE_CYC - 1);

  logic          lvl_q, lvl_d;
  logic [EW-1:0] cnt_q, cnt_d;
  logic          differ, due;

  assign differ = (ext_i != lvl_q);
  assign due    = differ && (cnt_q == LAST);

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (due) begin
      lvl_d = ext_i;
    end else if (differ) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign level_o    = lvl_q;
  assign fall_due_o = due && lvl_q;

  // R8: the gated level only ever moves to the level seen on the input
  p_gate_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(ext_i)));
endmodule

// File: rtl/ssq_cycle_timer.sv
module ssq_cycle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q >= (len_i - CNT_W'(1)));

  always_comb begin
    if (hold_i || wrap) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: the count never runs past the period it was given
  p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) >= ($past(len_i) - CNT_W'(1))) |-> (cnt_q == '0));
endmodule

// File: rtl/ssq_rate_ctl.sv
module ssq_rate_ctl #(
  parameter int TO_CYC = 2800000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_mode_i,
  input  logic smp_i,
  input  logic flip_i,
  output logic fast_o
);
  localparam int TW = $clog2(TO_CYC + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TO_CYC - 1);

  logic          fast_q, fast_d;
  logic [TW-1:0] tc_q, tc_d;

  always_comb begin
    fast_d = fast_q;
    tc_d   = tc_q;
    if (!act_mode_i) begin
      fast_d = 1'b0;
      tc_d   = '0;
    end else if (smp_i && flip_i) begin
      fast_d = 1'b1;
      tc_d   = '0;
    end else if (fast_q) begin
      if (tc_q == TO_LAST) begin
        fast_d = 1'b0;
        tc_d   = '0;
      end else begin
        tc_d = tc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      tc_q   <= '0;
    end else begin
      fast_q <= fast_d;
      tc_q   <= tc_d;
    end
  end

  assign fast_o = fast_q;

  p_fast_on_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode_i && smp_i && flip_i) |=> fast_q);
  p_timeout_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q <= TO_LAST) && (fast_q || tc_q == '0));
endmodule

// File: rtl/ssq_hyst_latch.sv
module ssq_hyst_latch #(
  parameter int FIELD_W = 12,
  parameter int OP_THR  = 36,
  parameter int RP_THR  = -36
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_i,
  input  logic signed [FIELD_W-1:0] field_i,
  output logic                      out_o,
  output logic                      flip_o
);
  localparam logic signed [FIELD_W-1:0] OP_F = FIELD_W'(OP_THR);
  localparam logic signed [FIELD_W-1:0] RP_F = FIELD_W'(RP_THR);

  logic out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (smp_i) begin
      if (field_i >= OP_F)      out_d = 1'b1;
      else if (field_i <= RP_F) out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_o  = out_q;
  assign flip_o = (out_d != out_q);

  p_set_above_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_i && field_i >= OP_F) |=> out_q);
  p_clear_below_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_i && field_i <= RP_F) |=> !out_q);
  p_hold_unsampled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> $past(smp_i));
endmodule

// File: rtl/sample_sleep_seq.sv
module sample_sleep_seq
  import ssq_pkg::*;
#(
  parameter int AWAKE_CYC       = 25,
  parameter int NORM_PERIOD     = 700,
  parameter int SLOW_PERIOD     = 28000,
  parameter int TIMEOUT_PERIODS = 100,
  parameter int FIELD_W         = 12,
  parameter int OP_THR          = 36,
  parameter int RP_THR          = -36
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                mode_sel,
  input  logic                      ext_clk,
  input  logic signed [FIELD_W-1:0] field,
  output logic                      awake,
  output logic                      sensor_out
);
  localparam int FAST_PERIOD = 8 * AWAKE_CYC;
  localparam int TO_CYC      = TIMEOUT_PERIODS * SLOW_PERIOD;
  localparam int MAX_A       = (NORM_PERIOD > SLOW_PERIOD) ? NORM_PERIOD : SLOW_PERIOD;
  localparam int MAX_P       = (MAX_A > FAST_PERIOD) ? MAX_A : FAST_PERIOD;
  localparam int CNT_W       = $clog2(MAX_P + 1);

  ssq_mode_e        mode_q, mode_eff, mode_dec;
  logic [CNT_W-1:0] cnt, len;
  logic             gate_lvl, gate_fall, fast, smp, flip, gated, take;

  assign mode_dec = (mode_sel == MODE_RSVD) ? MODE_FIXED : ssq_mode_e'(mode_sel);
  assign take     = (cnt == '0) && !((mode_q == MODE_GATED) && gate_lvl);
  assign mode_eff = take ? mode_dec : mode_q;
  assign gated    = (mode_eff == MODE_GATED);

  always_comb begin
    if (mode_eff == MODE_ACT) len = fast ? CNT_W'(FAST_PERIOD) : CNT_W'(SLOW_PERIOD);
    else                      len = CNT_W'(NORM_PERIOD);
  end

  always_comb begin
    if (gated) begin
      awake = gate_lvl;
      smp   = gate_fall;
    end else begin
      awake = (cnt < CNT_W'(AWAKE_CYC));
      smp   = (cnt == CNT_W'(AWAKE_CYC - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_FIXED;
    else        mode_q <= mode_eff;
  end

  ssq_ext_gate #(.AWAKE_CYC(AWAKE_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .ext_i(ext_clk),
    .level_o(gate_lvl), .fall_due_o(gate_fall)
  );

  ssq_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold_i(gated), .len_i(len), .cnt_o(cnt)
  );

  ssq_rate_ctl #(.TO_CYC(TO_CYC)) u_rate (
    .clk(clk), .rst_n(rst_n), .act_mode_i(mode_eff == MODE_ACT),
    .smp_i(smp), .flip_i(flip), .fast_o(fast)
  );

  ssq_hyst_latch #(.FIELD_W(FIELD_W), .OP_THR(OP_THR), .RP_THR(RP_THR)) u_latch (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .field_i(field),
    .out_o(sensor_out), .flip_o(flip)
  );

  p_sample_while_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp |-> awake);
  p_gated_sample_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && smp) |=> !gate_lvl);
  p_mode_held_mid_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (mode_eff == $past(mode_eff)));
endmodule

// File: tb/sim_sample_sleep_seq.sv
module sim_sample_sleep_seq;
  localparam int CLK_P = 10;
  localparam int A     = 3;
  localparam int NORM  = 12;
  localparam int SLOW  = 40;
  localparam int TOP   = 2;
  localparam int FW    = 8;
  localparam int OPT   = 36;
  localparam int RPT   = -36;
  localparam int FASTP = 8 * A;
  localparam int TOC   = TOP * SLOW;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [1:0]           mode_sel;
  logic                 ext_clk;
  logic signed [FW-1:0] field;
  logic                 awake, sensor_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sample_sleep_seq #(
    .AWAKE_CYC(A), .NORM_PERIOD(NORM), .SLOW_PERIOD(SLOW),
    .TIMEOUT_PERIODS(TOP), .FIELD_W(FW), .OP_THR(OPT), .RP_THR(RPT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ext_clk(ext_clk),
    .field(field), .awake(awake), .sensor_out(sensor_out)
  );

  // Reference model written from the requirements
  int   m_cnt, m_tc, m_ecnt;
  logic [1:0] m_mode;
  bit   m_fast, m_out, m_lvl;
  logic [1:0] e_mode;
  bit   e_awake, e_smp, e_out_n;
  int   e_len;

  always_comb begin
    logic [1:0] dec;
    dec    = (mode_sel == 2'b11) ? 2'b00 : mode_sel;
    e_mode = (m_cnt == 0 && !(m_mode == 2'b01 && m_lvl)) ? dec : m_mode;
    if (e_mode == 2'b01) begin
      e_awake = m_lvl;
      e_smp   = m_lvl && !ext_clk && (m_ecnt == A - 1);
    end else begin
      e_awake = (m_cnt < A);
      e_smp   = (m_cnt == A - 1);
    end
    e_len = (e_mode == 2'b10) ? (m_fast ? FASTP : SLOW) : NORM;
    e_out_n = m_out;
    if (e_smp) begin
      if (int'(field) >= OPT)      e_out_n = 1'b1;
      else if (int'(field) <= RPT) e_out_n = 1'b0;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_tc <= 0; m_ecnt <= 0; m_mode <= 2'b00;
      m_fast <= 1'b0; m_out <= 1'b0; m_lvl <= 1'b0;
    end else begin
      m_mode <= e_mode;
      m_out  <= e_out_n;
      if (ext_clk != m_lvl) begin
        if (m_ecnt == A - 1) begin m_lvl <= ext_clk; m_ecnt <= 0; end
        else m_ecnt <= m_ecnt + 1;
      end else m_ecnt <= 0;
      if (e_mode == 2'b01 || m_cnt >= e_len - 1) m_cnt <= 0;
      else m_cnt <= m_cnt + 1;
      if (e_mode != 2'b10) begin m_fast <= 1'b0; m_tc <= 0; end
      else if (e_smp && (e_out_n != m_out)) begin m_fast <= 1'b1; m_tc <= 0; end
      else if (m_fast) begin
        if (m_tc == TOC - 1) begin m_fast <= 1'b0; m_tc <= 0; end
        else m_tc <= m_tc + 1;
      end
    end
  end

  // Per-cycle comparison, sampled a quarter period after the rising edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      checks++;
      if (awake !== e_awake) begin
        fails++;
        case (e_mode)
          2'b01:   $display("FAIL R8 awake t=%0t actual=%0b expected=%0b", $time, awake, e_awake);
          2'b10:   $display("FAIL R5 R6 R7 awake t=%0t actual=%0b expected=%0b", $time, awake, e_awake);
          default: $display("FAIL R2 R3 R4 awake t=%0t actual=%0b expected=%0b", $time, awake, e_awake);
        endcase
      end
      checks++;
      if (sensor_out !== m_out) begin
        fails++;
        $display("FAIL R9 R10 R11 sensor_out t=%0t actual=%0b expected=%0b", $time, sensor_out, m_out);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; ext_clk = 1'b0; field = '0;
    run(3);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    checks++;
    if (sensor_out !== 1'b0 || awake !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset actual=%0b%0b expected=01", sensor_out, awake);
    end
    // R2 R9 R10: sweep every field value up then down, one period each
    for (int v = -128; v < 128; v++) begin field = FW'(v); run(NORM); end
    for (int v = 127; v >= -128; v--) begin field = FW'(v); run(NORM); end
    // R3 R4: reserved code, mode switches at odd offsets inside periods
    mode_sel = 2'b11;
    for (int k = 0; k < 6; k++) begin field = (k % 2) ? 8'sd50 : -8'sd50; run(NORM + k); end
    mode_sel = 2'b10; run(5); mode_sel = 2'b00; run(7); mode_sel = 2'b10;
    // R5: slow rate while idle
    field = '0; run(3 * SLOW);
    // R6: output flips on alternate windows
    for (int k = 0; k < 30; k++) begin field = (k % 2) ? 8'sd60 : -8'sd60; run(7); end
    // R7: hold still past the timeout, then repeat with different gaps
    field = 8'sd10; run(TOC + 2 * SLOW);
    for (int g = 1; g <= 4; g++) begin
      field = 8'sd90; run(SLOW + g);
      field = -8'sd90; run(g * 23);
      field = 8'sd0; run(TOC / 2 + g * 11);
    end
    // R8 R11: clock-gated mode, all short high/low pulse lengths
    mode_sel = 2'b01;
    for (int h = 1; h <= 8; h++) begin
      for (int l = 1; l <= 8; l++) begin
        field = ((h + l) % 2) ? 8'sd70 : -8'sd70;
        ext_clk = 1'b1; run(h);
        ext_clk = 1'b0; run(l);
      end
    end
    for (int k = 0; k < 10; k++) begin
      field = (k % 2) ? 8'sd70 : -8'sd70;
      ext_clk = 1'b1; run(6); ext_clk = 1'b0; run(6);
    end
    // R4: leave gated mode while asleep, then run fixed rate
    run(2 * A); mode_sel = 2'b00; run(3 * NORM);
    done = 1'b1;
    report();
  end
endmodule